// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

An 8-bit up-counter advances on ticks derived from the system clock: a free-running divider produces a clock enable at one quarter of the clock rate, and a selectable prescaler (1:1, 1:4 or 1:16) thins those enables further. Each tick, the count is compared with a programmable period value. When they are equal, the tick returns the count to zero and raises a one-clock match pulse. That pulse is exported unscaled so that a PWM generator or a serial shifter can use it as a time base.

The match pulses also feed a 4-bit postscaler. Its terminal count sets a sticky interrupt flag, and an enable bit gates that flag onto the interrupt line. Software reaches the count, the period, the control byte, the flag and the enable through a small synchronous register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 8'h00, the period reads 8'hFF, the control byte reads 8'h00, the flag and the enable read 0, and irq_o and match_o are low.
- R2: Register addresses are 0 for the count, 1 for the period, 2 for control, 3 for the flag (bit 0) and 4 for the enable (bit 0). Control bits 1:0 choose the prescale ratio: 2'b00 gives 1:1, 2'b01 gives 1:4, and 2'b10 or 2'b11 give 1:16. When running, two successive match pulses are 4 × ratio × (period + 1) clocks apart.
- R3: On the tick where the count equals the period, the count becomes 0 and match_o is high for exactly one clock.
- R4: Control bits 6:3 hold a value N. After a write to the control register, the flag sets on the (N+1)-th following match pulse, in the same clock that match_o rises.
- R5: Control bit 2 is the run bit. While it is 0, the count holds its value.
- R6: Control bit 7 always reads as 0, even when it has been written as 1.
- R7: The flag stays set until software writes 0 to it. If a hardware set and a software clear fall in the same clock, the set wins.
- R8: irq_o is high exactly when both the flag and the enable are 1.
- R9: A write to the count register loads the written value. A write to the count register or to the control register also clears the prescaler and postscaler progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| match_o | output | 1 | One-clock unscaled period-match pulse |
| irq_o | output | 1 | Flag gated by the enable |

## Verification
The hardest case to reach from the ports is a software clear of the flag that lands in the same clock as a hardware set. To reach it, the bench uses a period of 0, a 1:1 prescale ratio and a 1:1 postscale ratio. The flag then sets every fourth clock, in lockstep with match_o. The bench waits for an observed match pulse, counts three further clocks, and issues the clear so that it coincides with the next set. It repeats the clear one clock after a match to show that the clear works when the two do not collide. Period intervals and postscaler counts are measured between match pulses, so the unknown phase of the quarter-rate divider never enters an expected value.

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CW = 8,
  parameter int PSW = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          match_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_PER  = AW'(1);
  localparam logic [AW-1:0] A_CTL  = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);
  localparam logic [AW-1:0] A_EN   = AW'(4);

  logic [1:0]     qdiv;
  logic [3:0]     pre_cnt, pre_lim;
  logic [PSW-1:0] post_cnt;
  logic [CW-1:0]  cnt, period;
  logic [6:0]     ctl;
  logic           flag, en, match_q;

  wire run     = ctl[2];
  wire [PSW-1:0] post_lim = ctl[6:3];
  wire wr_cnt  = reg_wr && reg_addr == A_CNT;
  wire wr_per  = reg_wr && reg_addr == A_PER;
  wire wr_ctl  = reg_wr && reg_addr == A_CTL;
  wire wr_flag = reg_wr && reg_addr == A_FLAG;
  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire qtick   = qdiv == 2'd3;
  wire tick    = qtick && run && pre_cnt == pre_lim;
  wire hit     = tick && cnt == period;
  wire post_hit = hit && post_cnt == post_lim;

  always_comb begin
    case (ctl[1:0])
      2'b00:   pre_lim = 4'd0;
      2'b01:   pre_lim = 4'd3;
      default: pre_lim = 4'd15;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) qdiv <= '0;
    else        qdiv <= qdiv + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_cnt || wr_ctl) pre_cnt <= '0;
    else if (qtick && run)          pre_cnt <= (pre_cnt == pre_lim) ? 4'd0 : pre_cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_cnt) cnt <= reg_wdata;
    else if (tick)   cnt <= hit ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_cnt || wr_ctl) post_cnt <= '0;
    else if (hit) post_cnt <= (post_cnt == post_lim) ? '0 : post_cnt + PSW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period  <= '1;
      ctl     <= '0;
      flag    <= 1'b0;
      en      <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (wr_per) period <= reg_wdata;
      if (wr_ctl) ctl <= reg_wdata[6:0];
      if (wr_en)  en <= reg_wdata[0];
      flag <= post_hit | (wr_flag ? reg_wdata[0] : flag);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CNT:   reg_rdata = cnt;
      A_PER:   reg_rdata = period;
      A_CTL:   reg_rdata = {1'b0, ctl};
      A_FLAG:  reg_rdata = {7'd0, flag};
      A_EN:    reg_rdata = {7'd0, en};
      default: reg_rdata = '0;
    endcase
  end

  assign match_o = match_q;
  assign irq_o   = flag & en;

  p_match_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |=> !match_q);
  p_count_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_q && !$past(wr_cnt) |-> cnt == '0);
  p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_cnt |=> $stable(cnt));
  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && !$past(wr_flag) |-> match_q);
endmodule

// File: tb/period_timer_tb.sv
module period_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic match_o, irq_o;
  int checks = 0, errors = 0;

  period_timer u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_o(match_o), .irq_o(irq_o));

  always #4 clk = ~clk;

  // {prescale code[13:12], period[11:4], postscale[3:0]}
  localparam logic [13:0] VEC [6] = '{
    {2'b00, 8'd0, 4'd0}, {2'b01, 8'd2, 4'd1}, {2'b10, 8'd3, 4'd2},
    {2'b11, 8'd1, 4'd3}, {2'b00, 8'd9, 4'd15}, {2'b01, 8'd0, 4'd7}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic wait_match(output int clks);
    clks = 0;
    do begin
      @(negedge clk);
      clks++;
    end while (!match_o && clks < 20000);
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, gap, n, ratio;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); check("R1 count", v, 0);
    rd(3'd1, v); check("R1 period", v, 255);
    rd(3'd2, v); check("R1 control", v, 0);
    rd(3'd3, v); check("R1 flag", v, 0);
    rd(3'd4, v); check("R1 enable", v, 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 match", int'(match_o), 0);

    // R5 R9: load while stopped, then hold
    wr(3'd0, 8'd5);
    repeat (100) @(negedge clk);
    rd(3'd0, v); check("R5 R9 hold loaded count", v, 5);
    // R6: bit 7 reads 0
    wr(3'd2, 8'h80);
    rd(3'd2, v); check("R6 control bit7", v, 0);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] ps; logic [7:0] per; logic [3:0] pst;
      {ps, per, pst} = VEC[i];
      ratio = (ps == 2'b00) ? 1 : (ps == 2'b01) ? 4 : 16;
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h00);
      wr(3'd1, per);
      wr(3'd2, {1'b0, pst, 1'b1, ps});
      n = 0;
      do begin
        wait_match(gap);
        n++;
        rd(3'd3, v);
      end while (v == 0 && n < 40);
      check("R4 matches until flag", n, int'(pst) + 1);
      rd(3'd0, v); check("R3 count zero after match", v, 0);
      @(negedge clk);
      check("R3 match one cycle", int'(match_o), 0);
      wait_match(gap);
      wait_match(gap);
      check("R2 match interval", gap, 4 * ratio * (int'(per) + 1));
    end

    // R7 R8: flag every 4 clocks
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'h04);
    wait_match(gap);
    check("R8 irq gated off", int'(irq_o), 0);
    wr(3'd4, 8'h01);
    check("R8 irq with enable", int'(irq_o), 1);
    wait_match(gap);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h00;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd3, v); check("R7 clear between sets", v, 0);
    check("R8 irq low when flag clear", int'(irq_o), 0);
    wait_match(gap);
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h00;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    check("R7 collision match", int'(match_o), 1);
    rd(3'd3, v); check("R7 set beats clear", v, 1);
    // R7 sticky while stopped
    wr(3'd2, 8'h00);
    repeat (40) @(negedge clk);
    rd(3'd3, v); check("R7 flag sticky", v, 1);
    check("R5 no match while stopped", int'(match_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule